// File: doc/BRIEF.md
# USB IN Endpoint Bank Handoff Controller

This block runs the device side of a single USB IN endpoint that holds one or two data banks. Firmware fills the bank it currently owns through a byte write port. It then hands the bank over with a two-step flag handshake. The USB engine streams the committed banks out in commit order, one per IN token, and frees each bank once the host acknowledges it. A token that finds no committed bank is answered with a NAK pulse. A bank committed with no bytes is answered with a zero-length packet indication.

Two flags carry the handshake. `free_flag` is the interrupt-style notice and `own_flag` is the ownership bit. Both rise in the same cycle when the bank under the CPU pointer is free. Firmware clears `free_flag` with a strobe. Only after that may it release ownership, which commits the bank and moves the CPU pointer to the next bank. A flush input models a received SETUP: it empties every bank and clears every flag.

Top module: `usb_in_ep_banks`

## Requirements
- R1: One clock after the bank under the CPU pointer is free while `own_flag` is 0 (including the first clock after reset), `free_flag` and `own_flag` both become 1 in the same cycle.
- R2: `irq` is 1 exactly when `free_flag` is 1 and `int_en` is 1.
- R3: A `free_clr` pulse clears `free_flag` only. `own_flag`, the bank's stored bytes and its byte count are unchanged.
- R4: An `own_clr` pulse while `own_flag`=1 and `free_flag`=0 commits the bank with its current byte count and clears `own_flag` on the next clock. The CPU pointer moves to the next bank (it wraps; with one bank it stays). `own_flag` returns only through R1.
- R5: `room` is 1 exactly when `own_flag` is 1 and the current bank holds fewer than DEPTH bytes.
- R6: An IN token while the next bank to send is not committed gives a one-cycle `tx_nak` pulse on the clock after the token, with no data sent.
- R7: An `own_clr` pulse while `free_flag`=1 is ignored (`own_flag` stays 1). It sets `seq_err`, which stays 1 until reset or flush.
- R8: `ep_flush` clears every bank, both flags, both sticky error bits and both bank pointers on the next clock. A later token gets a NAK.
- R9: A token on a bank committed with zero bytes gives a one-cycle `tx_zlp` pulse on the next clock, and `tx_valid` stays 0.
- R10: A write while `room` is 0 is dropped and sets the sticky `overflow` bit.
- R11: A committed bank is streamed from byte 0 upward. `tx_valid` is high with the current byte, and a byte is consumed on each clock with `rd_rdy`=1. `tx_last` marks the final byte. `host_ack` then frees the bank, and banks go out in commit order.
- R12: `host_tmo` after streaming leaves the bank committed, and the next token resends it from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_flush | input | 1 | Endpoint flush (SETUP received) |
| int_en | input | 1 | Interrupt enable |
| cpu_wr | input | 1 | Byte write strobe into current bank |
| cpu_wdata | input | 8 | Byte to write |
| free_clr | input | 1 | Clear strobe for free_flag |
| own_clr | input | 1 | Release strobe: commit current bank |
| free_flag | output | 1 | Current bank became free |
| own_flag | output | 1 | CPU owns current bank |
| room | output | 1 | Current bank can take more bytes |
| irq | output | 1 | Endpoint interrupt |
| seq_err | output | 1 | Sticky: release attempted before flag clear |
| overflow | output | 1 | Sticky: a write was dropped |
| in_tok | input | 1 | IN token received |
| rd_rdy | input | 1 | USB engine takes the byte on tx_data |
| host_ack | input | 1 | Host acknowledged the packet |
| host_tmo | input | 1 | Host handshake timed out |
| tx_nak | output | 1 | Answer NAK to the token |
| tx_zlp | output | 1 | Send a zero-length packet |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_data | output | 8 | Byte to send |
| tx_last | output | 1 | tx_data is the final byte of the packet |

## Verification
The main handoff runs with a short bank, a bank filled exactly to capacity, and an empty commit. These show that the byte count is captured at commit, that `tx_last` marks the right byte, and that a zero count yields a zero-length packet and no data. Streaming runs under an irregular `rd_rdy` pattern, which tells a byte index that advances only on consumption from one that advances every cycle. A timeout followed by a resend separates a bank freed only on ACK from one freed on any handshake. The two banks are committed back to back and drained in order, which checks pointer wrap on both sides. The two handshake orders (flag cleared first and release first) check the error path.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic [7:0] data;
    } tx_beat_t;

    // wrap-around increment of a bank pointer
    function automatic int unsigned bump_ptr(input int unsigned p, input int unsigned nb);
        return (p + 1 >= nb) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
    parameter int DEPTH = 64,
    parameter int CW    = 7,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic          rel,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count,
    output logic          ready,
    output logic          full
);
    logic [7:0] mem [DEPTH];
    logic       do_wr;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !ready && !full;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (clr) begin
            count <= '0;
            ready <= 1'b0;
        end else if (rel) begin
            count <= '0;
            ready <= 1'b0;
        end else if (commit) begin
            ready <= 1'b1;
        end else if (do_wr) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[count[IW-1:0]] <= wr_data;
        end
    end
endmodule

// File: rtl/ep_cpu_side.sv
module ep_cpu_side #(
    parameter int NUM_BANKS = 2,
    parameter int PW        = 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          cpu_wr,
    input  logic          free_clr,
    input  logic          own_clr,
    input  logic          cur_ready,
    input  logic          cur_full,
    output logic          wr_ok,
    output logic          commit,
    output logic [PW-1:0] ptr,
    output logic          free_q,
    output logic          own_q,
    output logic          room,
    output logic          seq_err_q,
    output logic          ovf_q
);
    assign room   = own_q && !cur_full;
    assign wr_ok  = cpu_wr && room;
    assign commit = own_clr && own_q && !free_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ptr       <= '0;
            free_q    <= 1'b0;
            own_q     <= 1'b0;
            seq_err_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (commit) begin
                own_q <= 1'b0;
                ptr   <= PW'(usb_in_ep_pkg::bump_ptr(32'(ptr), NUM_BANKS));
            end else if (!own_q && !cur_ready) begin
                own_q  <= 1'b1;
                free_q <= 1'b1;
            end else if (free_clr) begin
                free_q <= 1'b0;
            end
            if (own_clr && own_q && free_q) seq_err_q <= 1'b1;
            if (cpu_wr && !wr_ok)           ovf_q     <= 1'b1;
        end
    end
endmodule

// File: rtl/ep_usb_side.sv
module ep_usb_side
    import usb_in_ep_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int PW        = 1,
    parameter int CW        = 7,
    parameter int IW        = 6
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          tok,
    input  logic          rd,
    input  logic          ack,
    input  logic          tmo,
    input  logic          bank_ready,
    input  logic [CW-1:0] bank_cnt,
    input  logic [7:0]    bank_data,
    output logic [IW-1:0] rd_idx,
    output logic [PW-1:0] ptr,
    output logic          rel,
    output tx_beat_t      beat,
    output logic          nak,
    output logic          zlp
);
    tx_state_e st;
    logic      at_last;

    assign at_last    = (CW'(rd_idx) + CW'(1) == bank_cnt);
    assign rel        = (st == TX_WAIT) && ack;
    assign beat.valid = (st == TX_SEND);
    assign beat.last  = (st == TX_SEND) && at_last;
    assign beat.data  = bank_data;

    always_ff @(posedge clk) begin
        if (clr) begin
            st     <= TX_IDLE;
            rd_idx <= '0;
            ptr    <= '0;
            nak    <= 1'b0;
            zlp    <= 1'b0;
        end else begin
            nak <= 1'b0;
            zlp <= 1'b0;
            unique case (st)
                TX_IDLE: begin
                    if (tok) begin
                        if (!bank_ready) begin
                            nak <= 1'b1;
                        end else if (bank_cnt == '0) begin
                            zlp <= 1'b1;
                            st  <= TX_WAIT;
                        end else begin
                            rd_idx <= '0;
                            st     <= TX_SEND;
                        end
                    end
                end
                TX_SEND: begin
                    if (rd) begin
                        if (at_last) begin
                            rd_idx <= '0;
                            st     <= TX_WAIT;
                        end else begin
                            rd_idx <= rd_idx + IW'(1);
                        end
                    end
                end
                TX_WAIT: begin
                    if (ack) begin
                        ptr <= PW'(bump_ptr(32'(ptr), NUM_BANKS));
                        st  <= TX_IDLE;
                    end else if (tmo) begin
                        st <= TX_IDLE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_in_ep_banks.sv
module usb_in_ep_banks
    import usb_in_ep_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int DEPTH     = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ep_flush,
    input  logic       int_en,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    input  logic       free_clr,
    input  logic       own_clr,
    output logic       free_flag,
    output logic       own_flag,
    output logic       room,
    output logic       irq,
    output logic       seq_err,
    output logic       overflow,
    input  logic       in_tok,
    input  logic       rd_rdy,
    input  logic       host_ack,
    input  logic       host_tmo,
    output logic       tx_nak,
    output logic       tx_zlp,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last
);
    localparam int PW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic           clr;
    logic           wr_ok, commit, rel;
    logic [PW-1:0]  cpu_ptr, usb_ptr;
    logic [IW-1:0]  rd_idx;
    logic [NUM_BANKS-1:0] ready_v, full_v;
    logic [CW-1:0]  cnt_a  [NUM_BANKS];
    logic [7:0]     data_a [NUM_BANKS];
    tx_beat_t       beat;

    assign clr = rst || ep_flush;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            ep_bank_store #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_bank (
                .clk     (clk),
                .clr     (clr),
                .wr_en   (wr_ok  && (cpu_ptr == PW'(b))),
                .wr_data (cpu_wdata),
                .commit  (commit && (cpu_ptr == PW'(b))),
                .rel     (rel    && (usb_ptr == PW'(b))),
                .rd_idx  (rd_idx),
                .rd_data (data_a[b]),
                .count   (cnt_a[b]),
                .ready   (ready_v[b]),
                .full    (full_v[b])
            );
        end
    endgenerate

    ep_cpu_side #(.NUM_BANKS(NUM_BANKS), .PW(PW)) u_cpu (
        .clk       (clk),
        .clr       (clr),
        .cpu_wr    (cpu_wr),
        .free_clr  (free_clr),
        .own_clr   (own_clr),
        .cur_ready (ready_v[cpu_ptr]),
        .cur_full  (full_v[cpu_ptr]),
        .wr_ok     (wr_ok),
        .commit    (commit),
        .ptr       (cpu_ptr),
        .free_q    (free_flag),
        .own_q     (own_flag),
        .room      (room),
        .seq_err_q (seq_err),
        .ovf_q     (overflow)
    );

    ep_usb_side #(.NUM_BANKS(NUM_BANKS), .PW(PW), .CW(CW), .IW(IW)) u_usb (
        .clk        (clk),
        .clr        (clr),
        .tok        (in_tok),
        .rd         (rd_rdy),
        .ack        (host_ack),
        .tmo        (host_tmo),
        .bank_ready (ready_v[usb_ptr]),
        .bank_cnt   (cnt_a[usb_ptr]),
        .bank_data  (data_a[usb_ptr]),
        .rd_idx     (rd_idx),
        .ptr        (usb_ptr),
        .rel        (rel),
        .beat       (beat),
        .nak        (tx_nak),
        .zlp        (tx_zlp)
    );

    assign irq      = free_flag && int_en;
    assign tx_valid = beat.valid;
    assign tx_data  = beat.data;
    assign tx_last  = beat.last;
endmodule

// File: rtl/usb_in_ep_banks_chk.sv
module usb_in_ep_banks_chk (
    input logic clk,
    input logic rst,
    input logic ep_flush,
    input logic cpu_wr,
    input logic free_clr,
    input logic own_clr,
    input logic free_flag,
    input logic own_flag,
    input logic room,
    input logic irq,
    input logic seq_err,
    input logic overflow,
    input logic tx_nak,
    input logic tx_zlp,
    input logic tx_valid,
    input logic tx_last
);
    assert_pair_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (own_flag && !$past(own_flag)) |-> free_flag);

    assert_irq_owned_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> own_flag);

    assert_flag_clear_keeps_own_R3: assert property (@(posedge clk) disable iff (rst)
        (free_clr && own_flag && !own_clr && !ep_flush) |=> own_flag);

    assert_commit_drops_own_R4: assert property (@(posedge clk) disable iff (rst)
        (own_clr && own_flag && !free_flag && !ep_flush) |=> !own_flag);

    assert_room_needs_own_R5: assert property (@(posedge clk) disable iff (rst)
        room |-> own_flag);

    assert_nak_no_data_R6: assert property (@(posedge clk) disable iff (rst)
        tx_nak |-> !tx_valid);

    assert_bad_order_R7: assert property (@(posedge clk) disable iff (rst)
        (own_clr && free_flag && !ep_flush) |=> (seq_err && own_flag));

    assert_seq_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !ep_flush) |=> seq_err);

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ep_flush |=> (!own_flag && !free_flag && !seq_err && !overflow && !tx_valid));

    assert_zlp_no_data_R9: assert property (@(posedge clk) disable iff (rst)
        tx_zlp |-> !tx_valid);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !room && !ep_flush) |=> overflow);

    assert_last_valid_R11: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);
endmodule

bind usb_in_ep_banks usb_in_ep_banks_chk u_chk (.*);

// File: tb/tb_usb_in_ep_banks.sv
`timescale 1ns/1ps
module tb_usb_in_ep_banks;
    localparam int DEPTH = 8;
    localparam int NB    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ep_flush = 0, int_en = 0, cpu_wr = 0, free_clr = 0, own_clr = 0;
    logic [7:0] cpu_wdata = 0;
    logic in_tok = 0, rd_rdy = 0, host_ack = 0, host_tmo = 0;
    logic free_flag, own_flag, room, irq, seq_err, overflow;
    logic tx_nak, tx_zlp, tx_valid, tx_last;
    logic [7:0] tx_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [8:0] exp_q [$];
    logic [4:0] lfsr = 5'h13;

    always #2.5 clk = ~clk;

    usb_in_ep_banks #(.NUM_BANKS(NB), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .ep_flush(ep_flush), .int_en(int_en),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .free_clr(free_clr), .own_clr(own_clr),
        .free_flag(free_flag), .own_flag(own_flag), .room(room), .irq(irq),
        .seq_err(seq_err), .overflow(overflow), .in_tok(in_tok), .rd_rdy(rd_rdy),
        .host_ack(host_ack), .host_tmo(host_tmo), .tx_nak(tx_nak), .tx_zlp(tx_zlp),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // irregular read-ready pattern
    always @(posedge clk) begin
        #1;
        lfsr   <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
        rd_rdy <= lfsr[0] | lfsr[3];
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && tx_valid && rd_rdy) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1ff);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R11 byte/last", {23'd0, tx_last, tx_data}, {23'd0, e});
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        cpu_wr = 1; cpu_wdata = d; step(); cpu_wr = 0;
    endtask

    task automatic pulse_free();
        free_clr = 1; step(); free_clr = 0;
    endtask

    task automatic pulse_own();
        own_clr = 1; step(); own_clr = 0;
    endtask

    task automatic token();
        in_tok = 1; step(); in_tok = 0;
    endtask

    task automatic push_bank(input logic [7:0] base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), 8'(base + i)});
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0 && !tx_valid) break;
            step();
        end
        check(req, exp_q.size(), 0);
        check(req, {31'd0, tx_valid}, 0);
    endtask

    task automatic handshake(input bit ok);
        if (ok) host_ack = 1; else host_tmo = 1;
        step();
        host_ack = 0; host_tmo = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset own", own_flag, 0);
        check("R8 reset flag", free_flag, 0);
        check("R5 reset room", room, 0);
        rst = 0;
        step();
        check("R1 own after reset", own_flag, 1);
        check("R1 flag after reset", free_flag, 1);
        check("R5 room empty bank", room, 1);
        check("R2 irq masked", irq, 0);
        int_en = 1; #0.5;
        check("R2 irq enabled", irq, 1);

        // token with nothing committed
        token();
        check("R6 nak", tx_nak, 1);
        check("R6 no data", tx_valid, 0);
        step();
        check("R6 nak one cycle", tx_nak, 0);

        // bank 0: three bytes, misordered release first
        wr_byte(8'h10); wr_byte(8'h11); wr_byte(8'h12);
        pulse_own();
        check("R7 own kept", own_flag, 1);
        check("R7 seq_err set", seq_err, 1);
        pulse_free();
        check("R3 flag cleared", free_flag, 0);
        check("R3 own kept", own_flag, 1);
        check("R2 irq drops", irq, 0);
        pulse_own();
        check("R4 own dropped", own_flag, 0);
        step();
        check("R4 next bank owned", own_flag, 1);
        check("R1 next bank flag", free_flag, 1);

        // bank 1: fill to capacity plus one extra
        for (int i = 0; i < DEPTH - 1; i++) wr_byte(8'(8'h40 + i));
        check("R5 room one left", room, 1);
        wr_byte(8'(8'h40 + DEPTH - 1));
        check("R5 room full", room, 0);
        check("R10 no overflow yet", overflow, 0);
        wr_byte(8'hee);
        check("R10 overflow", overflow, 1);
        pulse_free();
        pulse_own();
        step();
        check("R4 both busy", own_flag, 0);
        check("R7 seq_err sticky", seq_err, 1);

        // bank 0 sent, timed out, resent
        push_bank(8'h10, 3);
        token();
        drain("R11 bank0 first try");
        handshake(0);
        check("R12 still busy", own_flag, 0);
        push_bank(8'h10, 3);
        token();
        drain("R12 resend");
        handshake(1);
        step();
        check("R11 freed bank reowned", own_flag, 1);
        check("R1 freed bank flag", free_flag, 1);

        // bank 1 full packet
        push_bank(8'h40, DEPTH);
        token();
        drain("R11 full bank");
        handshake(1);

        // empty commit on bank 0
        pulse_free();
        pulse_own();
        token();
        check("R9 zlp", tx_zlp, 1);
        check("R9 no data", tx_valid, 0);
        handshake(1);
        check("R9 zlp one cycle", tx_zlp, 0);

        // flush with a committed bank
        step();
        check("R4 bank1 owned", own_flag, 1);
        wr_byte(8'ha5); wr_byte(8'h5a);
        pulse_free();
        pulse_own();
        ep_flush = 1; step(); ep_flush = 0;
        check("R8 own cleared", own_flag, 0);
        check("R8 seq_err cleared", seq_err, 0);
        check("R8 overflow cleared", overflow, 0);
        step();
        check("R8 reowned", own_flag, 1);
        token();
        check("R8 nak after flush", tx_nak, 1);
        check("R8 no data after flush", tx_valid, 0);
        repeat (4) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule